// File: doc/BRIEF.md
# Bit-Sliced Eight-Function ALU

This block is a purely combinational arithmetic and logic unit of parameterizable width. The default width is 4 bits. It is built from identical one-bit slices and a single ripple-carry adder chain. A 3-bit operation code picks one of eight functions: four bitwise functions (pass, AND, OR, invert) and four arithmetic functions (add, subtract, increment, decrement).

The operation code is not used to select among separately computed results. Instead, a small control decoder turns it into slice strobes and a starting carry. Each slice has two front-end stages that feed its full adder:

- an operand-shaping stage that makes the first adder input;
- a modifier stage that makes the second adder input.

For the bitwise functions, the second input and the starting carry are both held at zero. The bitwise result therefore passes through the adder without change. Two flags report unsigned and signed overflow for the arithmetic functions.

Top module: `alu_bitslice`

## Requirements
- R1: With opCode 3'b000 the result equals opA.
- R2: With opCode 3'b001 the result is opA AND opB, and with opCode 3'b010 it is opA OR opB.
- R3: With opCode 3'b011 the result is the bitwise inverse of opA.
- R4: With opCode 3'b100 the result is (opA + opB) modulo 2^WIDTH, and for every arithmetic code the first adder input of every slice equals the opA bit.
- R5: With opCode 3'b101 the result is (opA - opB) modulo 2^WIDTH. It is formed as opA plus the inverse of opB plus a starting carry of 1.
- R6: With opCode 3'b110 the result is (opA + 1) modulo 2^WIDTH. It is formed with a zero second input and a starting carry of 1. The starting carry is 1 only for codes 3'b101 and 3'b110.
- R7: With opCode 3'b111 the result is (opA - 1) modulo 2^WIDTH. It is formed with an all-ones second input and a starting carry of 0.
- R8: For arithmetic codes (bit 2 of opCode set), unsignedOvf equals the carry out of the top slice. Equivalently, it is bit WIDTH of opA + y + c0 computed without truncation, where y is the second adder input (opB, ~opB, 0 or all ones) and c0 is the starting carry.
- R9: For arithmetic codes, signedOvf is 1 exactly when the two's-complement sum of opA, y and c0 lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R10: For bitwise codes (bit 2 of opCode clear), unsignedOvf and signedOvf are both 0.
- R11: At WIDTH 4 with opA=5 and opB=3, codes 0 to 7 give results 5, 1, 7, 10, 8, 2, 6 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 3 | Function select |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| result | output | WIDTH | Function result |
| unsignedOvf | output | 1 | Unsigned overflow / carry out, arithmetic codes only |
| signedOvf | output | 1 | Two's-complement overflow, arithmetic codes only |

## Verification
The hardest cases to reach are the two edges of the signed range:

- subtracting the most negative value;
- decrementing the most negative value or incrementing the most positive value.

In these cases the carry into the top slice and the carry out of it disagree. At the default width the bench reaches all of them by walking every code against every operand pair. It then adds seeded random operands and directed cases at zero, all ones, the signed minimum and the signed maximum.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'b000,
    OP_AND  = 3'b001,
    OP_OR   = 3'b010,
    OP_NOT  = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_INC  = 3'b110,
    OP_DEC  = 3'b111
  } aluOp_e;

  // Strobes from the decoder to every slice and to the flag logic
  typedef struct packed {
    logic selHi;    // opcode bit 2: arithmetic group
    logic selMid;   // opcode bit 1
    logic selLo;    // opcode bit 0
    logic arithEn;  // arithmetic function active, flags meaningful
    logic carryIn;  // starting carry of the ripple chain
  } sliceCtrl_t;

endpackage

// File: rtl/alu_bitslice_ctrl.sv
module alu_bitslice_ctrl
  import alu_bitslice_pkg::*;
(
  input  logic [2:0] opCode,
  output sliceCtrl_t ctrl
);

  logic carryStart;

  // Starting carry is 1 for subtract and increment only
  assign carryStart = opCode[2] & (opCode[1] ^ opCode[0]);

  always_comb begin
    ctrl.selHi   = opCode[2];
    ctrl.selMid  = opCode[1];
    ctrl.selLo   = opCode[0];
    ctrl.arithEn = opCode[2];
    ctrl.carryIn = carryStart;
  end

  always_comb begin
    if (!opCode[2]) begin
      assert_logic_no_carry_R10: assert (carryStart == 1'b0)
        else $error("starting carry raised for bitwise code");
    end
    if (opCode == OP_SUB || opCode == OP_INC) begin
      assert_carry_sub_inc_R6: assert (ctrl.carryIn == 1'b1)
        else $error("starting carry missing for subtract/increment");
    end
  end

endmodule

// File: rtl/alu_bitslice_slice.sv
module alu_bitslice_slice
  import alu_bitslice_pkg::*;
(
  input  sliceCtrl_t ctrl,
  input  logic       aBit,
  input  logic       bBit,
  input  logic       carryInBit,
  output logic       sumBit,
  output logic       carryOutBit
);

  logic xOperand;
  logic yOperand;

  // Operand-shaping stage: performs the bitwise function, or passes opA
  always_comb begin
    if (ctrl.selHi) begin
      xOperand = aBit;
    end else begin
      unique case ({ctrl.selMid, ctrl.selLo})
        2'b00:   xOperand = aBit;
        2'b01:   xOperand = aBit & bBit;
        2'b10:   xOperand = aBit | bBit;
        default: xOperand = ~aBit;
      endcase
    end
  end

  // Modifier stage: B, ~B, 0 or 1 depending on the arithmetic function
  assign yOperand = (ctrl.selHi & ctrl.selLo & (ctrl.selMid | ~bBit))
                  | (ctrl.selHi & ~ctrl.selMid & ~ctrl.selLo & bBit);

  // Full adder
  assign sumBit      = xOperand ^ yOperand ^ carryInBit;
  assign carryOutBit = (xOperand & yOperand) | (carryInBit & (xOperand ^ yOperand));

  always_comb begin
    if (ctrl.arithEn) begin
      assert_arith_x_is_a_R4: assert (xOperand == aBit)
        else $error("first adder input differs from opA bit");
    end else begin
      assert_logic_y_zero_R2: assert (yOperand == 1'b0)
        else $error("second adder input nonzero for bitwise code");
    end
    if (ctrl.selHi && ctrl.selMid && ctrl.selLo) begin
      assert_dec_y_ones_R7: assert (yOperand == 1'b1)
        else $error("decrement second input not one");
    end
  end

endmodule

// File: rtl/alu_bitslice_datapath.sv
module alu_bitslice_datapath
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  sliceCtrl_t         ctrl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [WIDTH-1:0]   result,
  output logic               unsignedOvf,
  output logic               signedOvf
);

  localparam int TopIdx = WIDTH - 1;

  logic [WIDTH:0] carryChain;

  assign carryChain[0] = ctrl.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    alu_bitslice_slice uSlice (
      .ctrl        (ctrl),
      .aBit        (opA[i]),
      .bBit        (opB[i]),
      .carryInBit  (carryChain[i]),
      .sumBit      (result[i]),
      .carryOutBit (carryChain[i+1])
    );
  end

  assign unsignedOvf = ctrl.arithEn & carryChain[WIDTH];
  assign signedOvf   = ctrl.arithEn & (carryChain[WIDTH] ^ carryChain[TopIdx]);

  always_comb begin
    if (!ctrl.arithEn) begin
      assert_no_flags_logic_R10: assert (!unsignedOvf && !signedOvf)
        else $error("overflow flag raised for bitwise code");
      assert_logic_carry_quiet_R8: assert (carryChain[WIDTH] == 1'b0)
        else $error("carry out for bitwise code");
    end
    if (ctrl.arithEn && ctrl.selMid && !ctrl.selLo && unsignedOvf) begin
      assert_inc_wrap_zero_R6: assert (result == '0)
        else $error("increment carried out but result not zero");
    end
    if (ctrl.arithEn && ctrl.selMid && ctrl.selLo && !unsignedOvf) begin
      assert_dec_borrow_ones_R7: assert (result == '1)
        else $error("decrement borrowed but result not all ones");
    end
  end

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             unsignedOvf,
  output logic             signedOvf
);

  sliceCtrl_t ctrl;

  alu_bitslice_ctrl uCtrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_bitslice_datapath #(.WIDTH(WIDTH)) uData (
    .ctrl        (ctrl),
    .opA         (opA),
    .opB         (opB),
    .result      (result),
    .unsignedOvf (unsignedOvf),
    .signedOvf   (signedOvf)
  );

endmodule

// File: tb/alu_bitslice_test.sv
module alu_bitslice_test;

  localparam int W = 4;
  localparam int Span = 1 << W;
  localparam int Half = 1 << (W - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    opCode;
  logic [W-1:0]  opA;
  logic [W-1:0]  opB;
  logic [W-1:0]  result;
  logic          unsignedOvf;
  logic          signedOvf;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  alu_bitslice #(.WIDTH(W)) uut (
    .opCode      (opCode),
    .opA         (opA),
    .opB         (opB),
    .result      (result),
    .unsignedOvf (unsignedOvf),
    .signedOvf   (signedOvf)
  );

  function automatic string tagOf(input int op);
    case (op)
      0:       return "R1";
      1, 2:    return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int expResult(input int op, input int a, input int b);
    int r;
    case (op)
      0: r = a;
      1: r = a & b;
      2: r = a | b;
      3: r = ~a;
      4: r = a + b;
      5: r = a - b;
      6: r = a + 1;
      default: r = a - 1;
    endcase
    return r & (Span - 1);
  endfunction

  function automatic int yOf(input int op, input int b);
    case (op)
      4: return b;
      5: return (~b) & (Span - 1);
      6: return 0;
      7: return Span - 1;
      default: return 0;
    endcase
  endfunction

  function automatic int cOf(input int op);
    return (op == 5 || op == 6) ? 1 : 0;
  endfunction

  function automatic int toSigned(input int v);
    return (v >= Half) ? v - Span : v;
  endfunction

  function automatic bit expUov(input int op, input int a, input int b);
    if (op < 4) return 1'b0;
    return ((a + yOf(op, b) + cOf(op)) >= Span);
  endfunction

  function automatic bit expSov(input int op, input int a, input int b);
    int s;
    if (op < 4) return 1'b0;
    s = toSigned(a) + toSigned(yOf(op, b)) + cOf(op);
    return (s < -Half) || (s > Half - 1);
  endfunction

  task automatic applyCheck(input int op, input int a, input int b, input string extra);
    int er;
    bit eu;
    bit es;
    @(posedge clk);
    opCode = op[2:0];
    opA = a[W-1:0];
    opB = b[W-1:0];
    @(negedge clk);
    er = expResult(op, a, b);
    eu = expUov(op, a, b);
    es = expSov(op, a, b);
    checks++;
    if (int'(result) != er) begin
      failures++;
      $display("FAIL %s%s result op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tagOf(op), extra, op, a, b, result, er);
    end
    checks++;
    if (unsignedOvf != eu) begin
      failures++;
      $display("FAIL %s unsignedOvf op=%0d a=%0d b=%0d actual=%0b expected=%0b",
               (op < 4) ? "R10" : "R8", op, a, b, unsignedOvf, eu);
    end
    checks++;
    if (signedOvf != es) begin
      failures++;
      $display("FAIL %s signedOvf op=%0d a=%0d b=%0d actual=%0b expected=%0b",
               (op < 4) ? "R10" : "R9", op, a, b, signedOvf, es);
    end
  endtask

  initial begin
    int r11Exp[8];
    opCode = 3'b000;
    opA = '0;
    opB = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset / idle state: pass of zero, no flags (R1, R10)
    applyCheck(0, 0, 0, " idle");

    // R11: worked example, A=5 B=3
    r11Exp = '{5, 1, 7, 10, 8, 2, 6, 4};
    for (int op = 0; op < 8; op++) begin
      @(posedge clk);
      opCode = op[2:0];
      opA = 4'd5;
      opB = 4'd3;
      @(negedge clk);
      checks++;
      if (int'(result) != r11Exp[op]) begin
        failures++;
        $display("FAIL R11 op=%0d actual=%0d expected=%0d", op, result, r11Exp[op]);
      end
    end

    // Directed edges: signed min/max, zero, all ones (R5, R6, R7, R8, R9)
    applyCheck(5, 0, Half, " sub-min");
    applyCheck(5, Half, 1, " min-minus-one");
    applyCheck(6, Half - 1, 0, " inc-max");
    applyCheck(6, Span - 1, 0, " inc-wrap");
    applyCheck(7, Half, 0, " dec-min");
    applyCheck(7, 0, 0, " dec-zero");
    applyCheck(4, Half - 1, 1, " add-max");
    applyCheck(4, Span - 1, Span - 1, " add-ones");

    // Exhaustive sweep at the default width
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < Span; a++)
        for (int b = 0; b < Span; b++)
          applyCheck(op, a, b, "");

    // Seeded random stimulus
    void'($urandom(32'd20240611));
    for (int n = 0; n < 2000; n++)
      applyCheck(int'($urandom % 8), int'($urandom % Span), int'($urandom % Span), " rnd");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule